// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is a general-purpose I/O port of `NUM_PINS` lines (16 by default) with a small register interface. Three sources decide the level of every line. The CPU drives a line when its direction bit is set. An external peripheral drives it when the peripheral's own direction input is set. When neither drives it, the line takes the value of its pull-up bit. The CPU sets direction and pull-up through one control word of twice the pin count, in which the two settings for each pin sit side by side. A read of the data register returns the resolved levels of the lines and not the value the CPU stored.

Each write to the data or control register compares the resolved levels before the write with the levels after it. The XOR of the two is presented on a changed-bit vector in the following cycle. Each attached peripheral has a trigger mask, and it receives a one-cycle notification pulse when its mask overlaps the changed bits. The block also holds an interrupt-control register that can be written and read back, but the port itself generates no interrupts.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input with no pull-up, the stored CPU data and the interrupt-control register are zero, all register reads return zero while no peripheral drives, and no notification is pending.
- R2: A write to register 1 (control) sets the direction of pin n from bit 2n (1 = CPU drives) and its pull-up enable from bit 2n+1, both in the same write. A read of register 1 returns the same interleaved word.
- R3: The level of line n is (cpuDir & cpuData) | (periphDir & periphData) | (~(cpuDir | periphDir) & pullUp), evaluated bit by bit.
- R4: A read of register 0 (data) returns the resolved line levels in bits [NUM_PINS-1:0] and zeros above them, not the stored CPU data.
- R5: In the cycle after a write to register 0 or 1, `chgBits` equals the XOR of the resolved levels before and after the write. `chgNotify[p]` is high in that cycle exactly when trigger mask p ANDed with `chgBits` is nonzero. Both last one cycle only.
- R6: A data or control write that leaves every resolved level unchanged produces a zero `chgBits` and no notification.
- R7: A change of the peripheral inputs with no register write does not produce `chgBits` or a notification, although the line levels follow the new inputs.
- R8: A write to register 2 stores the low NUM_PINS bits as the interrupt-control value, which reads back at register 2. It changes no line and signals no change.
- R9: A write to register 3 (unmapped) changes no state, and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register select: 0 data, 1 control, 2 interrupt control, 3 unmapped |
| busWrEn | input | 1 | Write strobe for the selected register |
| busWrData | input | 2*NUM_PINS | Write data; data and interrupt control use the low NUM_PINS bits |
| busRdData | output | 2*NUM_PINS | Read data of the selected register, combinational |
| periphData | input | NUM_PINS | Level that the peripherals drive |
| periphDir | input | NUM_PINS | Per-pin drive enable of the peripherals |
| periphTrigMask | input | NUM_PERIPH*NUM_PINS | Trigger masks, peripheral p in slice p |
| lineLevel | output | NUM_PINS | Resolved level of each line |
| chgBits | output | NUM_PINS | Changed-bit vector, valid in the cycle after a write |
| chgNotify | output | NUM_PERIPH | One-cycle change pulse per peripheral |

## Verification
The hardest case to reach from the ports is a write that changes register state without moving any line. Examples are a data write to pins configured as inputs, or a pull-up change on pins that a peripheral already drives. Such writes must stay silent, while a write that moves only bits outside one peripheral's mask must notify the other peripheral alone. The stimulus first runs directed writes that build these overlaps. It then runs a long pseudo-random sweep that changes control words, data, peripheral drive and masks on the same edge as the writes, mixed with idle cycles, and each step's expected levels and change vectors are computed arithmetically from the resolution formula.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_INTC = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic wrIntc;
  } regStrb_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  output regStrb_t   strb,
  output regSel_e    rdSel
);

  always_comb begin
    rdSel       = regSel_e'(busAddr);
    strb        = '0;
    strb.wrData = busWrEn && (rdSel == REG_DATA);
    strb.wrCtrl = busWrEn && (rdSel == REG_CTRL);
    strb.wrIntc = busWrEn && (rdSel == REG_INTC);
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrb_t                       strb,
  input  regSel_e                        rdSel,
  input  logic [2*NUM_PINS-1:0]          busWrData,
  input  logic [NUM_PINS-1:0]            periphData,
  input  logic [NUM_PINS-1:0]            periphDir,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphTrigMask,
  output logic [2*NUM_PINS-1:0]          rdData,
  output logic [NUM_PINS-1:0]            lineLevel,
  output logic [NUM_PINS-1:0]            chgBits,
  output logic [NUM_PERIPH-1:0]          chgNotify
);

  localparam int BUS_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] cpuDir, cpuPull, cpuData, intcReg;
  logic [NUM_PINS-1:0] wrDir, wrPull;
  logic [NUM_PINS-1:0] nextDir, nextPull, nextData;
  logic [NUM_PINS-1:0] lineNow, lineNext, lineDiff;
  logic [BUS_W-1:0]    ctrlRead;
  logic [NUM_PERIPH-1:0] hitVec;
  logic                anyWr;

  function automatic logic [NUM_PINS-1:0] resolveLines(
    input logic [NUM_PINS-1:0] dirC, dataC, dirP, dataP, pull);
    return (dirC & dataC) | (dirP & dataP) | (~(dirC | dirP) & pull);
  endfunction

  // Interleaved control word: even bit = direction, odd bit = pull-up
  for (genvar g = 0; g < NUM_PINS; g++) begin : gUnpack
    assign wrDir[g]          = busWrData[2*g];
    assign wrPull[g]         = busWrData[2*g+1];
    assign ctrlRead[2*g]     = cpuDir[g];
    assign ctrlRead[2*g+1]   = cpuPull[g];
  end

  assign anyWr    = strb.wrData | strb.wrCtrl;
  assign nextDir  = strb.wrCtrl ? wrDir  : cpuDir;
  assign nextPull = strb.wrCtrl ? wrPull : cpuPull;
  assign nextData = strb.wrData ? busWrData[NUM_PINS-1:0] : cpuData;

  assign lineNow  = resolveLines(cpuDir, cpuData, periphDir, periphData, cpuPull);
  assign lineNext = resolveLines(nextDir, nextData, periphDir, periphData, nextPull);
  assign lineDiff = lineNow ^ lineNext;
  assign lineLevel = lineNow;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : gHit
    assign hitVec[p] = |(lineDiff & periphTrigMask[p*NUM_PINS +: NUM_PINS]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuDir    <= '0;
      cpuPull   <= '0;
      cpuData   <= '0;
      intcReg   <= '0;
      chgBits   <= '0;
      chgNotify <= '0;
    end else begin
      cpuDir    <= nextDir;
      cpuPull   <= nextPull;
      cpuData   <= nextData;
      if (strb.wrIntc) intcReg <= busWrData[NUM_PINS-1:0];
      chgBits   <= anyWr ? lineDiff : '0;
      chgNotify <= anyWr ? hitVec : '0;
    end
  end

  always_comb begin
    unique case (rdSel)
      REG_DATA: rdData = {{(BUS_W-NUM_PINS){1'b0}}, lineNow};
      REG_CTRL: rdData = ctrlRead;
      REG_INTC: rdData = {{(BUS_W-NUM_PINS){1'b0}}, intcReg};
      default:  rdData = '0;
    endcase
  end

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (ctrlRead == $past(busWrData))); // R2

  AST_UNDRIVEN_PULL: assert property (@(posedge clk) disable iff (!rstN)
    ((~(cpuDir | periphDir)) & (lineLevel ^ cpuPull)) == '0); // R3

  AST_NOTIFY_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (chgNotify != '0) |-> (chgBits != '0)); // R5

  AST_CHANGE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (chgBits != '0) |-> $past(strb.wrData || strb.wrCtrl)); // R7

  AST_INTC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrIntc |=> $stable(intcReg)); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [1:0]                     busAddr,
  input  logic                           busWrEn,
  input  logic [2*NUM_PINS-1:0]          busWrData,
  output logic [2*NUM_PINS-1:0]          busRdData,
  input  logic [NUM_PINS-1:0]            periphData,
  input  logic [NUM_PINS-1:0]            periphDir,
  input  logic [NUM_PERIPH*NUM_PINS-1:0] periphTrigMask,
  output logic [NUM_PINS-1:0]            lineLevel,
  output logic [NUM_PINS-1:0]            chgBits,
  output logic [NUM_PERIPH-1:0]          chgNotify
);

  regStrb_t strb;
  regSel_e  rdSel;

  gpio_port_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  gpio_port_datapath #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .rdSel          (rdSel),
    .busWrData      (busWrData),
    .periphData     (periphData),
    .periphDir      (periphDir),
    .periphTrigMask (periphTrigMask),
    .rdData         (busRdData),
    .lineLevel      (lineLevel),
    .chgBits        (chgBits),
    .chgNotify      (chgNotify)
  );

  AST_DATA_READ_LINES: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> (busRdData == {{NUM_PINS{1'b0}}, lineLevel})); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdData == '0)); // R9

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NQ = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [2*NP-1:0] busWrData = '0;
  logic [2*NP-1:0] busRdData;
  logic [NP-1:0] periphData = '0, periphDir = '0;
  logic [NQ*NP-1:0] periphTrigMask = '0;
  logic [NP-1:0] lineLevel, chgBits;
  logic [NQ-1:0] chgNotify;

  int nChecks = 0;
  int nFail = 0;
  logic [NP-1:0] mDir = '0, mPull = '0, mData = '0, mIntc = '0;
  logic [31:0] seed = 32'h1ACE_B00C;

  gpio_port #(.NUM_PINS(NP), .NUM_PERIPH(NQ)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .periphData(periphData),
    .periphDir(periphDir), .periphTrigMask(periphTrigMask),
    .lineLevel(lineLevel), .chgBits(chgBits), .chgNotify(chgNotify));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NP-1:0] expLines(input logic [NP-1:0] cd, cv, pd, pv, pu);
    return (cd & cv) | (pd & pv) | (~(cd | pd) & pu);
  endfunction

  function automatic logic [2*NP-1:0] packCtrl(input logic [NP-1:0] d, p);
    logic [2*NP-1:0] w;
    for (int i = 0; i < NP; i++) begin
      w[2*i]   = d[i];
      w[2*i+1] = p[i];
    end
    return w;
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic we, input logic [2*NP-1:0] wd,
                      input logic [NP-1:0] pv, input logic [NP-1:0] pd,
                      input logic [NQ*NP-1:0] msk);
    logic [NP-1:0] oldL, newL, d;
    logic [NQ-1:0] expN;
    string tag;
    @(negedge clk);
    chk("R5 pulse width", {30'b0, chgNotify}, 32'h0);
    busAddr = a; busWrEn = we; busWrData = wd;
    periphData = pv; periphDir = pd; periphTrigMask = msk;
    oldL = expLines(mDir, mData, pd, pv, mPull);
    if (we) begin
      case (a)
        2'd0: mData = wd[NP-1:0];
        2'd1: begin
          for (int i = 0; i < NP; i++) begin
            mDir[i]  = wd[2*i];
            mPull[i] = wd[2*i+1];
          end
        end
        2'd2: mIntc = wd[NP-1:0];
        default: ;
      endcase
    end
    newL = expLines(mDir, mData, pd, pv, mPull);
    d = (we && (a == 2'd0 || a == 2'd1)) ? (oldL ^ newL) : '0;
    for (int p = 0; p < NQ; p++) expN[p] = |(d & msk[p*NP +: NP]);
    if (!we) tag = "R7";
    else if (a == 2'd3) tag = "R9";
    else if (a == 2'd2) tag = "R8";
    else if (d == '0) tag = "R6";
    else tag = "R5";
    @(negedge clk);
    busWrEn = 1'b0;
    chk(tag, {16'b0, chgBits}, {16'b0, d});
    chk(tag, {30'b0, chgNotify}, {30'b0, expN});
    chk("R3", {16'b0, lineLevel}, {16'b0, newL});
    busAddr = 2'd0; #1;
    chk("R4", busRdData, {16'b0, newL});
    busAddr = 2'd1; #1;
    chk("R2", busRdData, packCtrl(mDir, mPull));
    busAddr = 2'd2; #1;
    chk("R8", busRdData, {16'b0, mIntc});
    busAddr = 2'd3; #1;
    chk("R9", busRdData, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {16'b0, lineLevel}, 32'h0);
    chk("R1", {30'b0, chgNotify}, 32'h0);
    busAddr = 2'd1; #1; chk("R1", busRdData, 32'h0);
    busAddr = 2'd2; #1; chk("R1", busRdData, 32'h0);
    busAddr = 2'd0; #1; chk("R1", busRdData, 32'h0);

    // pull-ups everywhere, nobody drives: all lines high
    step(2'd1, 1'b1, 32'hAAAA_AAAA, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    // data write while all pins are inputs: silent
    step(2'd0, 1'b1, 32'h0000_1234, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    // all outputs, pull-ups off
    step(2'd1, 1'b1, 32'h5555_5555, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    // change only upper nibble: only peripheral 1 notified
    step(2'd0, 1'b1, 32'h0000_9234, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    // interrupt-control write and unmapped write
    step(2'd2, 1'b1, 32'h0000_BEEF, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    step(2'd3, 1'b1, 32'hFFFF_FFFF, 16'h0, 16'h0, {16'hF000, 16'h00FF});
    // inputs with pull-ups, peripheral drives low: overrides pull-up, no write
    step(2'd1, 1'b1, 32'hAAAA_AAAA, 16'h0, 16'h0, {16'hFFFF, 16'hFFFF});
    step(2'd0, 1'b0, 32'h0, 16'h0000, 16'hFFFF, {16'hFFFF, 16'hFFFF});
    // pull-up change on driven pins: silent
    step(2'd1, 1'b1, 32'h0000_0000, 16'h0000, 16'hFFFF, {16'hFFFF, 16'hFFFF});

    for (int k = 0; k < 600; k++) begin
      logic [31:0] r1, r2, r3, r4;
      seed = nextRand(seed); r1 = seed;
      seed = nextRand(seed); r2 = seed;
      seed = nextRand(seed); r3 = seed;
      seed = nextRand(seed); r4 = seed;
      step(r1[1:0], r1[2] | r1[3], r2, r3[15:0], r3[31:16] & r4[15:0], {r4[31:24], 8'h00, 8'h00, r4[23:16]} ^ {r1[31:16], r1[31:16]});
    end

    @(negedge clk);
    chk("R5 pulse width", {30'b0, chgNotify}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule